// File: doc/BRIEF.md
# Byte/Word Configurable Memory Bus Front-End

This block is the device-side bus interface that sits between a parallel, strobe-driven host bus and a small 16-bit-wide on-chip memory array. A system clock samples four active-low strobes: chip enable, output enable, write enable and hardware reset. The block turns them into one of five bus operations: read, write, standby, output disable or reset. Data pins appear as three separate vectors (incoming value, outgoing value and per-pin output enable) so that the pad ring can build the tri-state buffers.

A width-select input picks word mode or byte mode. In word mode all sixteen data pins carry data and the address input is a word address. In byte mode only the lower eight pins carry data and pins 8 to 14 float. The top data pin then becomes an extra address input below bit zero, and it chooses which half of the addressed word appears on the lower pins. Bus writes never reach the array. They load a command latch (address, data and half-select) that a downstream controller takes together with a one-cycle valid pulse.

After power-up or a hardware reset the block sits in array-read mode, so plain reads return array contents. A command write takes it out of that mode, and reads then return the controller's status word. Writing the reset command code puts it back.

Top module: `bwbus_front`

## Requirements
- R1: A read (ceN=0, oeN=0, weN=1, hwResetN=1) sampled at a clock edge makes dqOe nonzero and puts the read value on dqOut from that edge until the next one.
- R2: A write (ceN=0, oeN=1, weN=0) keeps dqOe at zero and loads cmdAddr from addr. In word mode cmdData takes all of dqIn and cmdByteSel is 0. In byte mode cmdData takes {8'h00, dqIn[7:0]} and cmdByteSel takes dqIn[15].
- R3: With ceN=0, oeN=1 and weN=1, every pin is released (dqOe=0) after the sampling edge.
- R4: While hwResetN is low, dqOe is 0, dqOut is 0 and cmdValid is 0 at once, with no clock edge needed, and arrayMode is 1.
- R5: With ceN=1, every pin is released (dqOe=0) after the sampling edge, whatever the other strobes are.
- R6: In word mode (byteN=1) a read drives dqOe=16'hFFFF and dqOut equals the full 16-bit source word.
- R7: In byte mode (byteN=0) a read drives dqOe=16'h00FF with dqIn[15] acting as the half-select. A half-select of 0 puts source bits 7:0 on dqOut[7:0], a half-select of 1 puts bits 15:8 there, and dqOut[15:8] stays 0.
- R8: After reset arrayMode is 1, and reads return arrayRdata (the array word at addr) with no command issued first.
- R9: cmdValid pulses high for exactly one cycle after the first edge that samples ceN=0 and weN=0 together with oeN=1. Holding weN low longer gives no further pulse.
- R10: A latched write whose low data byte is not 8'hF0 clears arrayMode, and reads then return ctrlRdata with the same word/byte steering. A latched write whose low data byte is 8'hF0 sets arrayMode again.
- R11: With ceN=0, oeN=0 and weN=0 together, the block drives no pin, produces no cmdValid pulse and leaves arrayMode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| hwResetN | input | 1 | Active-low hardware reset; asynchronous assertion |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| byteN | input | 1 | Width select: 1 word mode, 0 byte mode |
| addr | input | ADDR_W | Word address |
| dqIn | input | DATA_W | Values arriving on the data pins (bit 15 is the half-select in byte mode) |
| dqOut | output | DATA_W | Values to drive on the data pins |
| dqOe | output | DATA_W | Per-pin output enable, 1 drives the pin |
| arrayRdata | input | DATA_W | Array word at addr |
| ctrlRdata | input | DATA_W | Controller status word, read outside array mode |
| arrayMode | output | 1 | 1 while reads return array data |
| cmdValid | output | 1 | One-cycle pulse per latched write |
| cmdAddr | output | ADDR_W | Latched write address |
| cmdByteSel | output | 1 | Latched half-select (0 in word mode) |
| cmdData | output | DATA_W | Latched write data |

## Verification
If the mode flag holds the wrong value, the first read after the fault returns the controller word in place of array data, or the reverse, one cycle after the read is sampled. If the write-edge history holds the wrong value, a held write strobe gives a second cmdValid pulse or a new write gives none, which shows up in the cycle after the write edge. If the lane steering holds the wrong value, the wrong half appears on the lower pins, or an upper enable stays set, on the first byte-mode read. The reference model compares every output each cycle, so each of these faults is reported within one clock of the first operation that exposes it.

// File: rtl/bwbus_pkg.sv
package bwbus_pkg;

  typedef enum logic [2:0] {
    OP_STANDBY,
    OP_READ,
    OP_WRITE,
    OP_OUT_OFF,
    OP_ILLEGAL
  } busOp_e;

  typedef struct packed {
    logic driveRead;   // present read data after this edge
    logic latchCmd;    // load the command latch at this edge
    logic byteMode;    // byte-wide pin configuration
    logic hiLane;      // upper half selected (byte mode only)
    logic useArray;    // source reads from the array
  } strobe_t;

  function automatic busOp_e decodeOp(input logic ceN, input logic oeN, input logic weN);
    busOp_e op;
    if (ceN)                op = OP_STANDBY;
    else if (!oeN && !weN)  op = OP_ILLEGAL;
    else if (!oeN)          op = OP_READ;
    else if (!weN)          op = OP_WRITE;
    else                    op = OP_OUT_OFF;
    return op;
  endfunction

endpackage

// File: rtl/bwbus_ctrl.sv
module bwbus_ctrl
  import bwbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    weN,
  input  logic    byteN,
  input  logic    laneSelPin,
  input  logic    cmdIsReset,
  output strobe_t strobes,
  output logic    arrayMode
);

  busOp_e op;
  logic   wrSelPrev;
  logic   wrSelNow;
  logic   latchNow;

  assign op       = decodeOp(ceN, oeN, weN);
  assign wrSelNow = !ceN && !weN;
  assign latchNow = (op == OP_WRITE) && !wrSelPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSelPrev <= 1'b0;
      arrayMode <= 1'b1;
    end else begin
      wrSelPrev <= wrSelNow;
      if (latchNow) arrayMode <= cmdIsReset;
    end
  end

  always_comb begin
    strobes.driveRead = (op == OP_READ);
    strobes.latchCmd  = latchNow;
    strobes.byteMode  = !byteN;
    strobes.hiLane    = !byteN && laneSelPin;
    strobes.useArray  = arrayMode;
  end

endmodule

// File: rtl/bwbus_datapath.sv
module bwbus_datapath
  import bwbus_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int RESET_CMD = 'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  input  logic [DATA_W-1:0] arrayRdata,
  input  logic [DATA_W-1:0] ctrlRdata,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe,
  output logic              cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdByteSel,
  output logic [DATA_W-1:0] cmdData,
  output logic              cmdIsReset
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] srcWord;
  logic [HALF_W-1:0] laneWord;
  logic [DATA_W-1:0] nextOut;
  logic [DATA_W-1:0] laneEnable;
  logic [DATA_W-1:0] capData;

  assign srcWord  = strobes.useArray ? arrayRdata : ctrlRdata;
  assign laneWord = strobes.hiLane ? srcWord[DATA_W-1:HALF_W] : srcWord[HALF_W-1:0];
  assign nextOut  = strobes.byteMode ? {{HALF_W{1'b0}}, laneWord} : srcWord;
  assign capData  = strobes.byteMode ? {{HALF_W{1'b0}}, dqIn[HALF_W-1:0]} : dqIn;
  assign cmdIsReset = (dqIn[HALF_W-1:0] == HALF_W'(RESET_CMD));

  // Lower half of the pins is always usable; upper half only in word mode.
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    if (g < HALF_W) begin : g_lo
      assign laneEnable[g] = 1'b1;
    end else begin : g_hi
      assign laneEnable[g] = !strobes.byteMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqOut      <= '0;
      dqOe       <= '0;
      cmdValid   <= 1'b0;
      cmdAddr    <= '0;
      cmdByteSel <= 1'b0;
      cmdData    <= '0;
    end else begin
      dqOe     <= strobes.driveRead ? laneEnable : '0;
      dqOut    <= strobes.driveRead ? nextOut : '0;
      cmdValid <= strobes.latchCmd;
      if (strobes.latchCmd) begin
        cmdAddr    <= addr;
        cmdData    <= capData;
        cmdByteSel <= strobes.hiLane;
      end
    end
  end

endmodule

// File: rtl/bwbus_front.sv
module bwbus_front
  import bwbus_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int RESET_CMD = 'hF0
) (
  input  logic              clk,
  input  logic              hwResetN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              byteN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] dqOe,
  input  logic [DATA_W-1:0] arrayRdata,
  input  logic [DATA_W-1:0] ctrlRdata,
  output logic              arrayMode,
  output logic              cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdByteSel,
  output logic [DATA_W-1:0] cmdData
);

  strobe_t strobes;
  logic    cmdIsReset;

  bwbus_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (hwResetN),
    .ceN        (ceN),
    .oeN        (oeN),
    .weN        (weN),
    .byteN      (byteN),
    .laneSelPin (dqIn[DATA_W-1]),
    .cmdIsReset (cmdIsReset),
    .strobes    (strobes),
    .arrayMode  (arrayMode)
  );

  bwbus_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RESET_CMD (RESET_CMD)
  ) u_dp (
    .clk        (clk),
    .rstN       (hwResetN),
    .strobes    (strobes),
    .addr       (addr),
    .dqIn       (dqIn),
    .arrayRdata (arrayRdata),
    .ctrlRdata  (ctrlRdata),
    .dqOut      (dqOut),
    .dqOe       (dqOe),
    .cmdValid   (cmdValid),
    .cmdAddr    (cmdAddr),
    .cmdByteSel (cmdByteSel),
    .cmdData    (cmdData),
    .cmdIsReset (cmdIsReset)
  );

endmodule

// File: rtl/bwbus_front_chk.sv
module bwbus_front_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              hwResetN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              byteN,
  input logic [DATA_W-1:0] dqOe,
  input logic              cmdValid,
  input logic              arrayMode
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_LANES = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  p_read_drives_r1: assert property (@(posedge clk) disable iff (!hwResetN)
    (!ceN && !oeN && weN) |=> (dqOe != '0));

  p_outdis_hiz_r3: assert property (@(posedge clk) disable iff (!hwResetN)
    (!ceN && oeN) |=> (dqOe == '0));

  p_reset_release_r4: assert property (@(posedge clk) disable iff (!hwResetN)
    $rose(hwResetN) |-> (dqOe == '0 && !cmdValid && arrayMode));

  p_standby_hiz_r5: assert property (@(posedge clk) disable iff (!hwResetN)
    ceN |=> (dqOe == '0));

  p_word_lanes_r6: assert property (@(posedge clk) disable iff (!hwResetN)
    (byteN && !ceN && !oeN && weN) |=> (dqOe == '1));

  p_byte_lanes_r7: assert property (@(posedge clk) disable iff (!hwResetN)
    (!byteN && !ceN && !oeN && weN) |=> (dqOe == LOW_LANES));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!hwResetN)
    cmdValid |=> !cmdValid);

  p_illegal_inert_r11: assert property (@(posedge clk) disable iff (!hwResetN)
    (!ceN && !oeN && !weN) |=> (dqOe == '0 && !cmdValid && $stable(arrayMode)));

endmodule

bind bwbus_front bwbus_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .hwResetN  (hwResetN),
  .ceN       (ceN),
  .oeN       (oeN),
  .weN       (weN),
  .byteN     (byteN),
  .dqOe      (dqOe),
  .cmdValid  (cmdValid),
  .arrayMode (arrayMode)
);

// File: tb/bwbus_front_test.sv
`timescale 1ns/1ps
module bwbus_front_test;

  logic        clk = 1'b0;
  logic        hwResetN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1, byteN = 1'b1;
  logic [17:0] addr = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] ctrlRdata = 16'h9E37;
  logic [15:0] arrayRdata;
  logic [15:0] dqOut, dqOe, cmdData;
  logic        arrayMode, cmdValid, cmdByteSel;
  logic [17:0] cmdAddr;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] memWord(input logic [17:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + {6'd0, a[17:16]}};
  endfunction

  assign arrayRdata = memWord(addr);

  bwbus_front uut (
    .clk(clk), .hwResetN(hwResetN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .byteN(byteN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .arrayRdata(arrayRdata), .ctrlRdata(ctrlRdata), .arrayMode(arrayMode),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdByteSel(cmdByteSel),
    .cmdData(cmdData)
  );

  // Behavioural reference model
  logic [15:0] mOe = '0, mOut = '0, mData = '0;
  logic [17:0] mAddr = '0;
  logic        mValid = 1'b0, mSel = 1'b0, mMode = 1'b1, mPrev = 1'b0;
  string       tagOe = "R4", tagOut = "R4";

  always @(posedge clk or negedge hwResetN) begin : model
    logic rd, wr, sel;
    logic [15:0] src;
    if (!hwResetN) begin
      mOe = '0; mOut = '0; mValid = 1'b0; mMode = 1'b1; mPrev = 1'b0;
      tagOe = "R4"; tagOut = "R4";
    end else begin
      rd  = !ceN && !oeN && weN;
      wr  = !ceN && !weN && oeN;
      sel = !ceN && !weN;
      src = mMode ? memWord(addr) : ctrlRdata;
      if (rd) begin
        tagOe = "R1";
        if (byteN) begin
          mOe = 16'hFFFF; mOut = src; tagOut = mMode ? "R6" : "R10";
        end else begin
          mOe  = 16'h00FF;
          mOut = dqIn[15] ? {8'h00, src[15:8]} : {8'h00, src[7:0]};
          tagOut = mMode ? "R7" : "R10";
        end
      end else begin
        mOe = '0; mOut = '0;
        tagOe = ceN ? "R5" : (!oeN && !weN) ? "R11" : !weN ? "R2" : "R3";
        tagOut = tagOe;
      end
      mValid = wr && !mPrev;
      if (mValid) begin
        mAddr = addr;
        mData = byteN ? dqIn : {8'h00, dqIn[7:0]};
        mSel  = !byteN && dqIn[15];
        mMode = (dqIn[7:0] == 8'hF0);
      end
      mPrev = sel;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(dqOe == mOe, tagOe, "dqOe", 32'(dqOe), 32'(mOe));
      check(dqOut == mOut, tagOut, "dqOut", 32'(dqOut), 32'(mOut));
      check(cmdValid == mValid, "R9", "cmdValid", 32'(cmdValid), 32'(mValid));
      check(arrayMode == mMode, mMode ? "R8" : "R10", "arrayMode", 32'(arrayMode), 32'(mMode));
      if (mValid) begin
        check(cmdAddr == mAddr, "R2", "cmdAddr", 32'(cmdAddr), 32'(mAddr));
        check(cmdData == mData, "R2", "cmdData", 32'(cmdData), 32'(mData));
        check(cmdByteSel == mSel, "R2", "cmdByteSel", 32'(cmdByteSel), 32'(mSel));
      end
    end
  end

  // Drive after the rising edge, hold for n cycles
  task automatic bus(input logic c, input logic o, input logic w, input logic b,
                     input logic [17:0] a, input logic [15:0] d, input int n);
    ceN = c; oeN = o; weN = w; byteN = b; addr = a; dqIn = d;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    hwResetN = 1'b1;
    // R8 / R6: default array reads in word mode
    bus(0, 0, 1, 1, 18'h00123, 16'h0000, 1);
    bus(0, 0, 1, 1, 18'h3ABCD, 16'h0000, 1);
    // R7: byte reads, both halves
    bus(0, 0, 1, 0, 18'h01F0F, 16'h0000, 1);
    bus(0, 0, 1, 0, 18'h01F0F, 16'h8000, 1);
    // R3 / R5: output disable and standby
    bus(0, 1, 1, 1, 18'h00001, 16'h0000, 2);
    bus(1, 0, 1, 1, 18'h00002, 16'h0000, 2);
    // R2 / R9 / R10: word write held 3 cycles, then reads of status
    bus(0, 1, 0, 1, 18'h2AAAA, 16'h1234, 3);
    bus(0, 1, 1, 1, 18'h00000, 16'h0000, 1);
    bus(0, 0, 1, 1, 18'h00055, 16'h0000, 1);
    bus(0, 0, 1, 0, 18'h00055, 16'h8000, 1);
    // R11: illegal combination, then oeN rising while weN held low
    bus(0, 0, 0, 1, 18'h00777, 16'h00F0, 2);
    bus(0, 1, 0, 1, 18'h00777, 16'h00F0, 2);
    bus(1, 1, 1, 1, 18'h00000, 16'h0000, 1);
    // R10: byte-mode reset command with upper half-select
    bus(0, 1, 0, 0, 18'h15555, 16'h80F0, 1);
    bus(1, 1, 1, 1, 18'h00000, 16'h0000, 1);
    bus(0, 0, 1, 1, 18'h00999, 16'h0000, 1);
    // R4: hardware reset mid-command-mode
    bus(0, 1, 0, 1, 18'h00010, 16'h0042, 1);
    bus(0, 0, 1, 1, 18'h00010, 16'h0000, 1);
    hwResetN = 1'b0;
    bus(0, 0, 1, 1, 18'h00010, 16'h0000, 2);
    hwResetN = 1'b1;
    bus(0, 0, 1, 1, 18'h00010, 16'h0000, 1);
    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) ctrlRdata = 16'($urandom);
      hwResetN = ($urandom_range(0, 299) != 0);
      bus(($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom), 1'($urandom),
          18'($urandom),
          ($urandom_range(0, 5) == 0) ? {1'($urandom), 7'($urandom), 8'hF0} : 16'($urandom),
          1);
    end
    hwResetN = 1'b1;
    bus(1, 1, 1, 1, 18'h0, 16'h0, 2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule